// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital side of a dual-slope integrating converter. It drives six analog switch enables and watches a comparator that monitors an external integrator. Every conversion runs through three phases in turn: a zeroing phase, in which the integrator loop settles and the reference capacitor is recharged; an integrate phase of fixed length, in which the input is integrated; and a deintegrate phase. In the deintegrate phase the reference of the opposite sign is applied until the comparator trips. The deintegrate switch is chosen from the comparator polarity captured on the last integrate clock, so one stored reference serves inputs of either sign.

The number of deintegrate clocks counted before the comparator trips is the reading. The sign comes from the captured polarity. The reading is presented with a one-cycle strobe and an over-range flag. A mode input selects a long conversion (10,000 integrate clocks, full scale 20,000, cycle 40,000 clocks) or a short one (1,000 / 2,000 / 4,000). The cycle period is fixed because clocks that an early comparator trip leaves unused are spent in the following zeroing phase. A run input lets conversions repeat. When run is low, the sequencer parks in the zeroing phase once the current cycle ends.

Top module: `dsadc_seq`

## Requirements
- R1: The phases run in the order zeroing, integrate, deintegrate, zeroing, and so on. After reset the sequencer is in the zeroing phase, and that first zeroing phase lasts one full cycle (4,000 clocks in short mode).
- R2: During the zeroing phase, sw_o[2:0] (switches 1, 2 and 3) are all high and sw_o[5:3] are low.
- R3: During the integrate phase, only sw_o[3] (switch 4) is high. The phase lasts 1,000 clocks when mode_i is 1 (short) and 10,000 clocks when mode_i is 0 (long). mode_i is taken at the start of integrate.
- R4: The comparator polarity is captured on the last integrate clock. In deintegrate, sw_o[5] (switch 6) is high if the polarity was high, and sw_o[4] (switch 5) is high if it was low. The two are never high together, and the choice does not change within a deintegrate phase.
- R5: cmp_i passes through a two-flop synchronizer. If cmp_i differs from the captured polarity from deintegrate clock d onward (d = 0 is the first deintegrate clock), deintegrate ends after clock d+2 and the magnitude is d+2. result_o is +magnitude when the polarity was high and −magnitude when it was low, in two's complement.
- R6: done_o is high for exactly one clock, the first zeroing clock after deintegrate, and result_o and ovr_o are valid from that clock.
- R7: If the comparator does not trip, deintegrate lasts exactly full scale (2,000 short / 20,000 long) clocks. The magnitude is then full scale and ovr_o is set. A conversion that ends on a comparator trip clears ovr_o.
- R8: While run_i is high and the mode is unchanged, successive integrate phases start exactly one cycle length apart (4,000 clocks short), whatever the deintegrate length.
- R9: When run_i is low, the current conversion still completes. The sequencer then stays in zeroing with no new integrate phase. Once run_i is high again at the end of zeroing, integrate starts on the next clock.
- R10: During and after reset, result_o is 0, and ovr_o and done_o are 0. result_o and ovr_o keep their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1: repeat conversions; 0: park in zeroing after the current cycle |
| mode_i | input | 1 | 1: short conversion, 0: long conversion |
| cmp_i | input | 1 | Integrator comparator, asynchronous |
| sw_o | output | 6 | Switch enables; bit n drives switch n+1 |
| result_o | output | 16 | Signed reading |
| done_o | output | 1 | One-cycle result strobe |
| ovr_o | output | 1 | Over-range flag for the last reading |

## Verification
The assertions check the switch patterns on every cycle: the zeroing set, integrate alone, and the exclusive and stable deintegrate pair. They also check that integrate follows zeroing and that deintegrate follows integrate, the one-cycle strobe, that the reading holds between strobes, that no integrate starts while run is low, and that an over-range reading equals full scale. Only the bench's scenarios can show the counted quantities. These are the integrate and deintegrate lengths in each mode, the magnitude and its sign for a given comparator trip time, the fixed cycle period, the length of the first zeroing phase, and the restart latency after a hold.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [1:0] {
    PH_ZERO = 2'd0,
    PH_INT  = 2'd1,
    PH_DEI  = 2'd2
  } phase_e;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dsadc_timer.sv
module dsadc_timer import dsadc_pkg::*; #(
  parameter int CYC_LONG  = 40000,
  parameter int CYC_SHORT = 4000,
  parameter int INT_LONG  = 10000,
  parameter int INT_SHORT = 1000
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  logic   mode_i,
  input  logic   dei_end_i,
  output phase_e phase_o,
  output logic   last_int_o,
  output logic   short_o
);
  localparam int CNT_W = $clog2(CYC_LONG);
  localparam logic [CNT_W-1:0] CYC_L_LAST = CNT_W'(CYC_LONG - 1);
  localparam logic [CNT_W-1:0] CYC_S_LAST = CNT_W'(CYC_SHORT - 1);
  localparam logic [CNT_W-1:0] INT_L_LAST = CNT_W'(INT_LONG - 1);
  localparam logic [CNT_W-1:0] INT_S_LAST = CNT_W'(INT_SHORT - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             short_q;
  logic             eff_short;
  logic [CNT_W-1:0] cyc_last, int_last;

  // mode is live during zeroing, frozen from integrate start
  assign eff_short = (ph_q == PH_ZERO) ? mode_i : short_q;
  assign cyc_last  = eff_short ? CYC_S_LAST : CYC_L_LAST;
  assign int_last  = eff_short ? INT_S_LAST : INT_L_LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_ZERO;
      cnt_q   <= '0;
      short_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_ZERO: begin
          if (cnt_q >= cyc_last) begin
            if (run_i) begin
              ph_q    <= PH_INT;
              cnt_q   <= '0;
              short_q <= mode_i;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_INT: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == int_last) ph_q <= PH_DEI;
        end
        PH_DEI: begin
          cnt_q <= cnt_q + 1'b1;
          if (dei_end_i) ph_q <= PH_ZERO;
        end
        default: ph_q <= PH_ZERO;
      endcase
    end
  end

  assign phase_o    = ph_q;
  assign last_int_o = (ph_q == PH_INT) && (cnt_q == int_last);
  assign short_o    = short_q;
endmodule

// File: rtl/dsadc_capture.sv
module dsadc_capture import dsadc_pkg::*; #(
  parameter int FS_LONG  = 20000,
  parameter int FS_SHORT = 2000
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  phase_e                                 phase_i,
  input  logic                                   last_int_i,
  input  logic                                   short_i,
  input  logic                                   cmp_i,
  output logic                                   dei_end_o,
  output logic                                   pol_o,
  output logic signed [$clog2(FS_LONG+1):0]      result_o,
  output logic                                   done_o,
  output logic                                   ovr_o
);
  localparam int MAG_W = $clog2(FS_LONG + 1);
  localparam int RES_W = MAG_W + 1;
  localparam logic [MAG_W-1:0] FS_L_LAST = MAG_W'(FS_LONG - 1);
  localparam logic [MAG_W-1:0] FS_S_LAST = MAG_W'(FS_SHORT - 1);

  logic             pol_q;
  logic [MAG_W-1:0] dcnt_q;
  logic [MAG_W-1:0] fs_last, mag;
  logic             in_dei, crossed, full;
  logic [RES_W-1:0] mag_ext;

  assign in_dei    = (phase_i == PH_DEI);
  assign fs_last   = short_i ? FS_S_LAST : FS_L_LAST;
  assign crossed   = in_dei && (cmp_i != pol_q);
  assign full      = in_dei && !crossed && (dcnt_q == fs_last);
  assign dei_end_o = crossed || full;
  assign mag       = full ? fs_last + 1'b1 : dcnt_q;
  assign mag_ext   = {1'b0, mag};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q    <= 1'b0;
      dcnt_q   <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
      ovr_o    <= 1'b0;
    end else begin
      done_o <= dei_end_o;
      if (last_int_i) begin
        pol_q  <= cmp_i;
        dcnt_q <= '0;
      end else if (in_dei) begin
        dcnt_q <= dcnt_q + 1'b1;
      end
      if (dei_end_o) begin
        ovr_o    <= full;
        result_o <= pol_q ? $signed(mag_ext) : -$signed(mag_ext);
      end
    end
  end

  assign pol_o = pol_q;
endmodule

// File: rtl/dsadc_swdrv.sv
module dsadc_swdrv import dsadc_pkg::*; (
  input  phase_e     phase_i,
  input  logic       pol_i,
  output logic [5:0] sw_o
);
  always_comb begin
    sw_o = '0;
    unique case (phase_i)
      PH_ZERO: sw_o[2:0] = 3'b111;
      PH_INT:  sw_o[3]   = 1'b1;
      PH_DEI:  begin
        sw_o[4] = !pol_i;
        sw_o[5] = pol_i;
      end
      default: sw_o = '0;
    endcase
  end
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq import dsadc_pkg::*; #(
  parameter int CYC_LONG    = 40000,
  parameter int CYC_SHORT   = 4000,
  parameter int INT_LONG    = 10000,
  parameter int INT_SHORT   = 1000,
  parameter int FS_LONG     = 20000,
  parameter int FS_SHORT    = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        run_i,
  input  logic        mode_i,
  input  logic        cmp_i,
  output logic [5:0]  sw_o,
  output logic [15:0] result_o,
  output logic        done_o,
  output logic        ovr_o
);
  localparam int RES_W = $clog2(FS_LONG + 1) + 1;

  phase_e                   phase;
  logic                     last_int, short_m, dei_end, pol, cmp_s;
  logic signed [RES_W-1:0]  res;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(cmp_i), .q_o(cmp_s)
  );

  dsadc_timer #(
    .CYC_LONG(CYC_LONG), .CYC_SHORT(CYC_SHORT),
    .INT_LONG(INT_LONG), .INT_SHORT(INT_SHORT)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .mode_i    (mode_i),
    .dei_end_i (dei_end),
    .phase_o   (phase),
    .last_int_o(last_int),
    .short_o   (short_m)
  );

  dsadc_capture #(.FS_LONG(FS_LONG), .FS_SHORT(FS_SHORT)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .phase_i   (phase),
    .last_int_i(last_int),
    .short_i   (short_m),
    .cmp_i     (cmp_s),
    .dei_end_o (dei_end),
    .pol_o     (pol),
    .result_o  (res),
    .done_o    (done_o),
    .ovr_o     (ovr_o)
  );

  dsadc_swdrv u_sw (.phase_i(phase), .pol_i(pol), .sw_o(sw_o));

  assign result_o = 16'($signed(res));
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int FS_LONG  = 20000,
  parameter int FS_SHORT = 2000
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        run_i,
  input logic [5:0]  sw_o,
  input logic [15:0] result_o,
  input logic        done_o,
  input logic        ovr_o
);
  logic [15:0] mag;
  assign mag = result_o[15] ? 16'(-result_o) : result_o;

  AST_ZERO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_o[2] |-> (sw_o[1:0] == 2'b11) && (sw_o[5:3] == 3'b000)); // R2
  AST_INT_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_o[3] |-> (sw_o == 6'b001000)); // R3
  AST_DEI_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_o[4] && sw_o[5])); // R4
  AST_DEI_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_o[5] |=> !sw_o[4]); // R4
  AST_DEI_STEADY_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_o[4] |=> !sw_o[5]); // R4
  AST_SOME_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_o[2] || sw_o[3] || sw_o[4] || sw_o[5]); // R1
  AST_INT_AFTER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_o[3]) |-> $past(sw_o[2])); // R1
  AST_DEI_AFTER_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_o[3]) |-> (sw_o[4] || sw_o[5])); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_IN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sw_o[2] && $past(sw_o[4] || sw_o[5])); // R6
  AST_OVR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovr_o) |-> (mag == 16'(FS_SHORT) || mag == 16'(FS_LONG))); // R7
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o) && $stable(ovr_o)); // R10
  AST_HOLD_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && sw_o[2]) |=> !sw_o[3]); // R9
endmodule

bind dsadc_seq dsadc_seq_chk #(.FS_LONG(FS_LONG), .FS_SHORT(FS_SHORT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_i),
  .sw_o    (sw_o),
  .result_o(result_o),
  .done_o  (done_o),
  .ovr_o   (ovr_o)
);

// File: tb/sim_dsadc_seq.sv
`timescale 1ns/1ps
module sim_dsadc_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b1;
  logic        mode_i = 1'b1;
  logic        cmp_i = 1'b1;
  logic [5:0]  sw_o;
  logic [15:0] result_o;
  logic        done_o, ovr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  dsadc_seq u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .mode_i(mode_i),
    .cmp_i(cmp_i), .sw_o(sw_o), .result_o(result_o), .done_o(done_o),
    .ovr_o(ovr_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    int n;
    @(negedge clk_i);
    check(sw_o == 6'b000111, "R2 switches in reset", sw_o, 7);
    check(result_o == 16'd0, "R10 result in reset", result_o, 0);
    check({done_o, ovr_o} == 2'b00, "R10 flags in reset", {done_o, ovr_o}, 0);
    rst_ni = 1'b1;
    n = 0;
    while (!sw_o[3]) begin
      if (sw_o != 6'b000111) n = n + 100000;
      n++;
      @(negedge clk_i);
    end
    check(n == 4000, "R1 first zeroing length", n, 4000);
  endtask

  // one conversion: wait for integrate, trip comparator at deintegrate clock d
  task automatic t_conv(input bit pos, input int d, input bit trip, input int exp_int,
                        input int exp_val, input bit exp_ovr, input int exp_dei);
    int n, c, dei;
    cmp_i = pos;
    while (sw_o[3]) @(negedge clk_i);
    while (!sw_o[3]) @(negedge clk_i);
    n = 0;
    while (sw_o[3]) begin n++; @(negedge clk_i); end
    check(n == exp_int, "R3 integrate length", n, exp_int);
    check(sw_o[5] == pos && sw_o[4] == !pos, "R4 deintegrate switch", sw_o[5:4], pos ? 2 : 1);
    c = 0; dei = 0;
    while (!done_o) begin
      if (sw_o[4] | sw_o[5]) dei++;
      if (trip && c == d) cmp_i = !pos;
      c++;
      @(negedge clk_i);
    end
    check(dei == exp_dei, "R5 R7 deintegrate length", dei, exp_dei);
    check(int'($signed(result_o)) == exp_val, "R5 signed reading", int'($signed(result_o)), exp_val);
    check(ovr_o == exp_ovr, "R7 over-range flag", ovr_o, exp_ovr);
    check(sw_o == 6'b000111, "R1 R2 zeroing after done", sw_o, 7);
    @(negedge clk_i);
    check(!done_o, "R6 done one cycle", done_o, 0);
  endtask

  task automatic t_period();
    int n;
    cmp_i = 1'b1;
    while (sw_o[3]) @(negedge clk_i);
    while (!sw_o[3]) @(negedge clk_i);
    n = 0;
    do begin @(negedge clk_i); n++; end while (sw_o[3]);
    while (!sw_o[3]) begin @(negedge clk_i); n++; end
    check(n == 4000, "R8 cycle period", n, 4000);
  endtask

  task automatic t_hold();
    int n, bad;
    logic [15:0] held;
    cmp_i = 1'b0;
    while (sw_o[3]) @(negedge clk_i);
    while (!sw_o[3]) @(negedge clk_i);
    run_i = 1'b0;
    n = 0;
    while (!done_o && n < 5000) begin @(negedge clk_i); n++; end
    check(done_o == 1'b1, "R9 current conversion completes", done_o, 1);
    check(int'($signed(result_o)) == -2000, "R7 negative full scale", int'($signed(result_o)), -2000);
    held = result_o;
    @(negedge clk_i);
    bad = 0;
    for (int i = 0; i < 6000; i++) begin
      if (sw_o != 6'b000111 || done_o) bad++;
      @(negedge clk_i);
    end
    check(bad == 0, "R9 parked in zeroing", bad, 0);
    check(result_o == held, "R10 result held", result_o, held);
    run_i = 1'b1;
    @(negedge clk_i);
    n = 1;
    while (!sw_o[3] && n < 10) begin @(negedge clk_i); n++; end
    check(n == 1, "R9 restart latency", n, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_conv(1'b1, 500, 1'b1, 1000, 502, 1'b0, 503);
    t_conv(1'b0, 100, 1'b1, 1000, -102, 1'b0, 103);
    t_conv(1'b0, 0, 1'b0, 1000, -2000, 1'b1, 2000);
    t_conv(1'b1, 0, 1'b1, 1000, 2, 1'b0, 3);
    t_period();
    t_hold();
    mode_i = 1'b0;
    t_conv(1'b1, 15000, 1'b1, 10000, 15002, 1'b0, 15003);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule